// File: doc/BRIEF.md
# Eight-Channel Capture/Compare Timer

This block is a 16-bit up-counter with eight channels that share it. The counter advances once every 2^k clocks, where software picks k from 0 to 7. Software sets each channel to one of two modes. In capture mode, the channel watches a pin for a chosen transition and stores the counter value at which it arrived. In compare mode, the channel raises a flag and changes an output pin when the counter reaches the value in its register. Compare mode serves both waveform generation and software delays.

Software drives everything through a word-wide register port. It writes with a single strobe and reads through a combinational data path. Every counter and channel access moves the whole 16-bit value in one cycle. Status appears as eight channel flags and one wrap flag. Software clears them by writing ones. A clear takes effect only while the timer is enabled.

Top module: `tmr_capcomp`

## Requirements
- R1: After synchronous reset, every register reads zero, and ch_out, ch_oe, ch_flag and ovf_flag are all zero.
- R2: While the enable bit (CTRL bit 0) is set, the counter adds one every 2^PS clocks, where PS is CTRL bits 3:1. The first increment comes 2^PS clocks after enabling or after a counter write. With enable clear, the counter holds its value.
- R3: When the counter advances from 0xFFFF, it becomes 0x0000 and sets the wrap flag. The wrap flag is FLAGS bit 8 and the ovf_flag pin.
- R4: Register map, with word access. 0x0 is CTRL. 0x1 is MODE (bit i = 1 selects compare for channel i). 0x2 is EDGE (two bits per channel at [2i+1:2i]). 0x3 is ACTION (same layout). 0x4 is FLAGS (bits 7:0 channel, bit 8 wrap). 0x5 is COUNT. 0x8+i is the channel i register. Unused addresses and unused bits read 0.
- R5: For a capture channel, a qualifying pin edge stores the counter value in the channel register and sets the channel flag. This happens three clocks after the pin changes: two for the synchronizer and one for the detect. Capture needs the timer enabled.
- R6: The edge code selects which transitions capture. 00 selects none, 01 rising, 10 falling and 11 both.
- R7: A compare channel matches when the counter advances to the channel register value. On the next clock edge, the flag sets and ch_out takes the action. Action 01 toggles, 10 drives low and 11 drives high. Capture channels never change ch_out.
- R8: Action 00 leaves ch_out unchanged on a match. ch_oe[i] is high exactly when channel i is in compare mode with a nonzero action.
- R9: Writing ones to FLAGS clears those flags only while the timer is enabled. With the timer disabled, the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ch_in | input | 8 | Channel capture pins (asynchronous) |
| ch_out | output | 8 | Channel compare outputs |
| ch_oe | output | 8 | Channel output enables |
| ch_flag | output | 8 | Channel event flags |
| ovf_flag | output | 1 | Counter wrap flag |

## Verification
The bench checks the slowest prescale at the exact cycle of the first increment. A prescaler that is not restarted by a counter write, or that has an off-by-one mask, moves that increment by at least one clock. It aims a falling edge at a rising-only capture channel. It also tries a flag clear while the timer is disabled. A design that ignores the edge code captures the wrong edge, and a design that ignores the enable gate loses the wrap flag. For compare outputs, the bench samples one clock before and one clock after the expected change. A match taken one cycle early or late shows up at once, and so does a swapped toggle, set or clear code.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } out_act_e;

    localparam logic [3:0] A_CTRL  = 4'h0;
    localparam logic [3:0] A_MODE  = 4'h1;
    localparam logic [3:0] A_EDGE  = 4'h2;
    localparam logic [3:0] A_ACT   = 4'h3;
    localparam logic [3:0] A_FLAGS = 4'h4;
    localparam logic [3:0] A_COUNT = 4'h5;

    // Low bits that must all be one before a prescaled tick.
    function automatic logic [6:0] ps_mask(input logic [2:0] sel);
        logic [6:0] m;
        m = '0;
        for (int i = 0; i < 7; i++) begin
            if (i < int'(sel)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic edge_hit(input edge_sel_e sel, input logic cur, input logic prv);
        case (sel)
            EDGE_RISE: return cur & ~prv;
            EDGE_FALL: return ~cur & prv;
            EDGE_ANY:  return cur ^ prv;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic apply_act(input out_act_e a, input logic q);
        case (a)
            ACT_TOGGLE: return ~q;
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            default:    return q;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PS_W = 7,
    localparam int SEL_W = $clog2(PS_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    import tmr_pkg::*;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;

    assign mask = PS_W'(ps_mask(3'(sel)));
    assign tick = en && ((ps_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !en || restart) ps_q <= '0;
        else                       ps_q <= ps_q + 1'b1;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  cmp_mode,
    input  tmr_pkg::edge_sel_e    edge_sel,
    input  tmr_pkg::out_act_e     act,
    input  logic [CNT_W-1:0]      cnt,
    input  logic                  cnt_upd,
    input  logic                  pin_in,
    input  logic                  reg_wr,
    input  logic [CNT_W-1:0]      wdata,
    input  logic                  flag_clr,
    output logic [CNT_W-1:0]      reg_q,
    output logic                  flag,
    output logic                  pin_out
);
    import tmr_pkg::*;

    logic sync1_q, sync2_q, prev_q;
    logic cap_ev, cmp_ev;

    assign cap_ev = en && !cmp_mode && edge_hit(edge_sel, sync2_q, prev_q);
    assign cmp_ev = en && cmp_mode && cnt_upd && (cnt == reg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
            reg_q   <= '0;
            flag    <= 1'b0;
            pin_out <= 1'b0;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
            if (cap_ev)      reg_q <= cnt;
            else if (reg_wr) reg_q <= wdata;
            if (cap_ev || cmp_ev) flag <= 1'b1;
            else if (flag_clr)    flag <= 1'b0;
            if (cmp_ev) pin_out <= apply_act(act, pin_out);
        end
    end
endmodule

// File: rtl/tmr_capcomp.sv
module tmr_capcomp #(
    parameter int CNT_W = 16,
    parameter int N_CH  = 8,
    parameter int PS_W  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]  ch_in,
    output logic [N_CH-1:0]  ch_out,
    output logic [N_CH-1:0]  ch_oe,
    output logic [N_CH-1:0]  ch_flag,
    output logic             ovf_flag
);
    import tmr_pkg::*;

    localparam int SEL_W = $clog2(PS_W + 1);

    logic              ctrl_en;
    logic [SEL_W-1:0]  psel_q;
    logic [N_CH-1:0]   mode_q;
    logic [2*N_CH-1:0] edge_q;
    logic [2*N_CH-1:0] act_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              cnt_upd_q;
    logic              tick;
    logic              wr_ctrl, wr_mode, wr_edge, wr_act, wr_flags, cnt_wr;
    logic [N_CH-1:0]   chan_wr;
    logic [N_CH-1:0]   flag_clr;
    logic [CNT_W-1:0]  ccr [N_CH];
    logic [N_CH*CNT_W-1:0] ccr_flat;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_mode  = bus_wr && (bus_addr == A_MODE);
    assign wr_edge  = bus_wr && (bus_addr == A_EDGE);
    assign wr_act   = bus_wr && (bus_addr == A_ACT);
    assign wr_flags = bus_wr && (bus_addr == A_FLAGS);
    assign cnt_wr   = bus_wr && (bus_addr == A_COUNT);
    assign flag_clr = (wr_flags && ctrl_en) ? bus_wdata[N_CH-1:0] : '0;

    tmr_prescaler #(.PS_W(PS_W)) u_ps (
        .clk(clk), .rst(rst), .en(ctrl_en), .restart(cnt_wr),
        .sel(psel_q), .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en   <= 1'b0;
            psel_q    <= '0;
            mode_q    <= '0;
            edge_q    <= '0;
            act_q     <= '0;
            cnt_q     <= '0;
            cnt_upd_q <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            if (wr_ctrl) {psel_q, ctrl_en} <= bus_wdata[SEL_W:0];
            if (wr_mode) mode_q <= bus_wdata[N_CH-1:0];
            if (wr_edge) edge_q <= bus_wdata[2*N_CH-1:0];
            if (wr_act)  act_q  <= bus_wdata[2*N_CH-1:0];
            if (cnt_wr)    cnt_q <= bus_wdata;
            else if (tick) cnt_q <= cnt_q + 1'b1;
            cnt_upd_q <= tick && !cnt_wr;
            if (tick && !cnt_wr && (cnt_q == '1))        ovf_flag <= 1'b1;
            else if (wr_flags && ctrl_en && bus_wdata[N_CH]) ovf_flag <= 1'b0;
        end
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        assign chan_wr[i] = bus_wr && bus_addr[3] && (bus_addr[2:0] == 3'(i));
        assign ch_oe[i]   = mode_q[i] && (act_q[2*i +: 2] != 2'b00);
        assign ccr_flat[i*CNT_W +: CNT_W] = ccr[i];
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst(rst), .en(ctrl_en), .cmp_mode(mode_q[i]),
            .edge_sel(edge_sel_e'(edge_q[2*i +: 2])),
            .act(out_act_e'(act_q[2*i +: 2])),
            .cnt(cnt_q), .cnt_upd(cnt_upd_q), .pin_in(ch_in[i]),
            .reg_wr(chan_wr[i]), .wdata(bus_wdata), .flag_clr(flag_clr[i]),
            .reg_q(ccr[i]), .flag(ch_flag[i]), .pin_out(ch_out[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[3]) begin
            bus_rdata = ccr[bus_addr[2:0]];
        end else begin
            case (bus_addr)
                A_CTRL:  bus_rdata[SEL_W:0]    = {psel_q, ctrl_en};
                A_MODE:  bus_rdata[N_CH-1:0]   = mode_q;
                A_EDGE:  bus_rdata[2*N_CH-1:0] = edge_q;
                A_ACT:   bus_rdata[2*N_CH-1:0] = act_q;
                A_FLAGS: bus_rdata[N_CH:0]     = {ovf_flag, ch_flag};
                A_COUNT: bus_rdata             = cnt_q;
                default: bus_rdata             = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_capcomp_chk.sv
module tmr_capcomp_chk #(
    parameter int CNT_W = 16,
    parameter int N_CH  = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  en,
    input logic                  cnt_wr,
    input logic [CNT_W-1:0]      cnt,
    input logic                  ovf_flag,
    input logic [N_CH-1:0]       ch_flag,
    input logic [N_CH-1:0]       ch_out,
    input logic [N_CH-1:0]       mode,
    input logic [N_CH*CNT_W-1:0] ccr_flat
);
    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> (cnt == '0));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(en) && !$past(cnt_wr)) |-> $stable(cnt));

    assert_clear_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(en)) |->
            (((ch_flag & $past(ch_flag)) == $past(ch_flag)) && !($past(ovf_flag) && !ovf_flag)));

    for (genvar i = 0; i < N_CH; i++) begin : g_a
        assert_capture_value_R5: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $rose(ch_flag[i]) && !$past(mode[i])) |->
                (ccr_flat[i*CNT_W +: CNT_W] == $past(cnt)));

        assert_compare_hit_R7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $rose(ch_flag[i]) && $past(mode[i])) |->
                ($past(cnt) == $past(ccr_flat[i*CNT_W +: CNT_W])));

        assert_capture_pin_idle_R7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(mode[i])) |-> $stable(ch_out[i]));
    end
endmodule

bind tmr_capcomp tmr_capcomp_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
    .clk(clk), .rst(rst), .en(ctrl_en), .cnt_wr(cnt_wr), .cnt(cnt_q),
    .ovf_flag(ovf_flag), .ch_flag(ch_flag), .ch_out(ch_out),
    .mode(mode_q), .ccr_flat(ccr_flat)
);

// File: tb/tmr_capcomp_tb.sv
module tmr_capcomp_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  ch_in = '0;
    logic [7:0]  ch_out, ch_oe, ch_flag;
    logic        ovf_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tmr_capcomp u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_in(ch_in),
        .ch_out(ch_out), .ch_oe(ch_oe), .ch_flag(ch_flag), .ovf_flag(ovf_flag)
    );

    // {address, write data, expected read-back}
    localparam logic [35:0] VEC [0:7] = '{
        {4'h1, 16'h01A5, 16'h00A5},
        {4'h2, 16'h1B2C, 16'h1B2C},
        {4'h3, 16'hFFFF, 16'hFFFF},
        {4'h5, 16'hBEEF, 16'hBEEF},
        {4'hB, 16'h1357, 16'h1357},
        {4'hF, 16'hFFFF, 16'hFFFF},
        {4'h0, 16'hFFFE, 16'h000E},
        {4'h6, 16'h5555, 16'h0000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cap_try(input int ch, input logic [1:0] code, input logic pin,
                           input logic exp_flag, input logic [15:0] val);
        logic [15:0] r;
        wr(4'h4, 16'h00FF);
        wr(4'h2, 16'(code) << (2 * ch));
        wr(4'h5, val);
        ch_in[ch] = pin;
        repeat (5) @(negedge clk);
        rd(4'h4, r);
        chk("R6 capture edge code flag", 16'(r[ch]), 16'(exp_flag));
        if (exp_flag) begin
            rd(4'(8 + ch), r);
            chk("R5 captured counter value", r, val);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] r, v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), r);
            chk("R1 register reset value", r, 16'h0000);
        end
        chk("R1 outputs after reset", {ch_out, ch_oe}, 16'h0000);
        chk("R1 flags after reset", {7'b0, ovf_flag, ch_flag}, 16'h0000);

        // R4: register map walk
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][35:32], VEC[i][31:16]);
            rd(VEC[i][35:32], r);
            chk("R4 register read-back", r, VEC[i][15:0]);
        end
        wr(4'h0, 16'h0000); wr(4'h1, 16'h0000); wr(4'h2, 16'h0000); wr(4'h3, 16'h0000);

        // R2: divide by 4
        wr(4'h5, 16'h0000);
        wr(4'h0, 16'h0005);
        repeat (40) @(negedge clk);
        rd(4'h5, r);
        chk("R2 count at divide-by-4", r, 16'd10);
        wr(4'h0, 16'h0000);
        rd(4'h5, v);
        repeat (20) @(negedge clk);
        rd(4'h5, r);
        chk("R2 count frozen while disabled", r, v);
        // R2: divide by 1
        wr(4'h5, 16'h0000);
        wr(4'h0, 16'h0001);
        repeat (10) @(negedge clk);
        rd(4'h5, r);
        chk("R2 count at divide-by-1", r, 16'd10);
        // R2: divide by 128, first increment exactly after 128 clocks
        wr(4'h0, 16'h000F);
        wr(4'h5, 16'h0000);
        repeat (127) @(negedge clk);
        rd(4'h5, r);
        chk("R2 divide-by-128 before tick", r, 16'd0);
        @(negedge clk);
        rd(4'h5, r);
        chk("R2 divide-by-128 first tick", r, 16'd1);

        // R3: wrap and overflow flag
        wr(4'h0, 16'h0001);
        wr(4'h5, 16'hFFFE);
        @(negedge clk);
        rd(4'h5, r);
        chk("R3 count before wrap", r, 16'hFFFF);
        chk("R3 wrap flag before wrap", 16'(ovf_flag), 16'h0);
        @(negedge clk);
        rd(4'h5, r);
        chk("R3 count after wrap", r, 16'h0000);
        rd(4'h4, r);
        chk("R3 wrap flag set", r, 16'h0100);
        wr(4'h4, 16'h0100);
        rd(4'h4, r);
        chk("R9 clear while enabled", r, 16'h0000);

        // R9: clear ignored while disabled
        wr(4'h5, 16'hFFFE);
        repeat (3) @(negedge clk);
        wr(4'h0, 16'h0000);
        wr(4'h4, 16'h01FF);
        rd(4'h4, r);
        chk("R9 clear ignored while disabled", r, 16'h0100);
        wr(4'h0, 16'h0001);
        wr(4'h4, 16'h0100);
        rd(4'h4, r);
        chk("R9 clear after re-enable", r, 16'h0000);

        // R5/R6: capture on channel 2 with frozen counter (divide 128)
        wr(4'h0, 16'h000F);
        cap_try(2, 2'b01, 1'b1, 1'b1, 16'h1234);
        cap_try(2, 2'b01, 1'b0, 1'b0, 16'h1111);
        cap_try(2, 2'b10, 1'b1, 1'b0, 16'h2222);
        cap_try(2, 2'b10, 1'b0, 1'b1, 16'h2345);
        cap_try(2, 2'b11, 1'b1, 1'b1, 16'h3456);
        cap_try(2, 2'b11, 1'b0, 1'b1, 16'h4567);
        cap_try(2, 2'b00, 1'b1, 1'b0, 16'h5555);
        chk("R7 capture channel output idle", {8'h00, ch_out}, 16'h0000);

        // R7/R8: compare, round 1 (ch0 toggle, ch1 high, ch2 high)
        wr(4'h0, 16'h0000);
        wr(4'h4, 16'h00FF);
        wr(4'h2, 16'h0000);
        wr(4'h1, 16'h0007);
        wr(4'h3, 16'h003D);
        wr(4'h8, 16'h0010); wr(4'h9, 16'h0010); wr(4'hA, 16'h0010);
        chk("R8 output enables", {8'h00, ch_oe}, 16'h0007);
        wr(4'h0, 16'h0001);
        wr(4'h5, 16'h000D);
        repeat (3) @(negedge clk);
        chk("R7 output before match latency", {8'h00, ch_out}, 16'h0000);
        chk("R7 flag before match latency", {8'h00, ch_flag}, 16'h0000);
        @(negedge clk);
        chk("R7 toggle/high actions", {8'h00, ch_out}, 16'h0007);
        chk("R7 compare flags", {8'h00, ch_flag}, 16'h0007);

        // round 2 (ch0 toggle, ch1 none, ch2 low)
        wr(4'h4, 16'h00FF);
        wr(4'h3, 16'h0021);
        chk("R8 output enables with action 00", {8'h00, ch_oe}, 16'h0005);
        wr(4'h5, 16'h000D);
        repeat (4) @(negedge clk);
        chk("R7 toggle/low, R8 none holds", {8'h00, ch_out}, 16'h0002);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule